// File: doc/BRIEF.md
# Interlocked Clock Source Control Register

This block is an eight-bit control register that software writes to choose clock sources. It refuses any write that would leave the system clock without a valid source. It produces the select and enable signals for the clock tree: the slow-clock source select, the system-clock source select, a stop request to the PLL, and gated enables for two auxiliary clock prescalers. The dividers, the glitch-free multiplexers, the oscillators and the PLL are outside the block.

The system-clock source and the PLL power state are held by one state machine with three states:
- `ST_MAIN_PLLOFF`: main clock selected, PLL stopped. This is the reset state.
- `ST_MAIN_PLLON`: main clock selected, PLL running.
- `ST_ON_PLL`: PLL selected, PLL running.

The transitions are:
- `T_POWER_UP`: any write with the power-down bit 0 moves `ST_MAIN_PLLOFF` to `ST_MAIN_PLLON`.
- `T_POWER_DOWN`: a write with power-down 1, and without a successful PLL selection, moves `ST_MAIN_PLLON` to `ST_MAIN_PLLOFF`.
- `T_TO_PLL`: a write with the fast-select bit 0 while the PLL is stable moves `ST_MAIN_PLLON` to `ST_ON_PLL`.
- `T_TO_MAIN`: a write with the fast-select bit 1 moves `ST_ON_PLL` to `ST_MAIN_PLLON`.
- `T_FALLBACK`: loss of PLL stability forces `ST_ON_PLL` to `ST_MAIN_PLLON`, whatever is being written.

The state in which the PLL is selected while powered down cannot be reached. A separate flag records that a power-on reset has occurred. That flag is cleared only when software writes a 1 to it.

Top module: `clk_src_ctrl`

## Requirements
- R1: Read layout is: bit 0 slow select, bit 1 fast select, bit 2 PLL power-down, bit 3 aux1 enable, bit 4 aux2 enable, bit 5 power-on flag, bits 7:6 zero. After power-on reset, rd_data is 0x26: fast select 1, power-down 1, flag 1, all others 0.
- R2: Bit 0 is stored from any write and drives slow_sel_o: 1 selects the 32.768 kHz oscillator, 0 the prescaled main clock.
- R3: A write with bit 1 = 0 leaves fast select at 1 when the power-down bit held before the write is 1.
- R4: A write with bit 1 = 0 leaves fast select at 1 while pll_stable_i is low.
- R5: A write with bit 2 = 1 leaves power-down at 0 while fast select is 0. A write of bits 1 and 2 both 1 from `ST_ON_PLL` sets fast select to 1 and keeps power-down at 0.
- R6: From `ST_MAIN_PLLON` with the PLL stable, a write with bit 1 = 0 and bit 2 = 1 selects the PLL and keeps power-down at 0.
- R7: pll_stop_o equals the power-down bit. sys_sel_o equals the fast-select bit, where 1 means the main clock.
- R8: aux_en_o[i] is 1 only while its register bit (bit 3 + i) is 1 and main_stable_i is high. Both aux bits reset to 0.
- R9: The power-on flag (bit 5) is set by por_i and cleared by a write with bit 5 = 1. Reset through rst_n alone leaves the flag unchanged.
- R10: Writes to bits 7:6 have no effect, and those bits read as 0.
- R11: When pll_stable_i is low while the PLL is selected, fast select returns to 1 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset; does not touch the power-on flag |
| por_i | input | 1 | Power-on reset indication, active high; resets all bits and sets the flag |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current register contents |
| pll_stable_i | input | 1 | PLL output is stable |
| main_stable_i | input | 1 | Main oscillator is stable |
| slow_sel_o | output | 1 | Slow-clock source select |
| sys_sel_o | output | 1 | System-clock source: 1 main clock, 0 PLL |
| pll_stop_o | output | 1 | PLL stop request |
| aux_en_o | output | 2 | Gated auxiliary prescaler enables |

## Verification
The bench writes all-zero values from `ST_MAIN_PLLOFF`. A design that checked the new power-down bit rather than the held one would switch to a PLL that was still starting. It also issues the two writes that request opposite interlocks in one cycle. A design that resolved either of them the wrong way would reach the state where the PLL is selected and stopped, which is illegal. It drops PLL stability while the PLL is selected; if the forced fallback is missing, the system clock stays on a dead source. It also toggles main_stable_i with the aux bits set, to catch enables that are latched rather than gated, and it applies rst_n alone to catch a power-on flag that is cleared by the wrong reset.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
    // Fixed field positions; decoded by software and by the read mux.
    localparam int REG_W    = 8;
    localparam int AUX_N    = 2;
    localparam int SLOW_BIT = 0;
    localparam int FAST_BIT = 1;
    localparam int PWD_BIT  = 2;
    localparam int AUX_LSB  = 3;
    localparam int POR_BIT  = AUX_LSB + AUX_N;

    typedef enum logic [1:0] {
        ST_MAIN_PLLOFF = 2'd0,
        ST_MAIN_PLLON  = 2'd1,
        ST_ON_PLL      = 2'd2
    } src_state_e;
endpackage

// File: rtl/ccr_src_fsm.sv
module ccr_src_fsm
    import ccr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic req_fast,
    input  logic req_pwd,
    input  logic pll_stable,
    output logic fast_sel,
    output logic pll_pwd
);
    src_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_MAIN_PLLOFF;
        else        state_q <= state_d;
    end

    // Interlocks are judged against the held state, not the written value.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_MAIN_PLLOFF: begin
                if (wr_en && !req_pwd) state_d = ST_MAIN_PLLON;      // T_POWER_UP
            end
            ST_MAIN_PLLON: begin
                if (wr_en) begin
                    if (!req_fast && pll_stable) state_d = ST_ON_PLL;          // T_TO_PLL
                    else if (req_pwd)            state_d = ST_MAIN_PLLOFF;     // T_POWER_DOWN
                end
            end
            ST_ON_PLL: begin
                if (!pll_stable)             state_d = ST_MAIN_PLLON;  // T_FALLBACK
                else if (wr_en && req_fast)  state_d = ST_MAIN_PLLON;  // T_TO_MAIN
            end
            default: state_d = ST_MAIN_PLLOFF;
        endcase
    end

    always_comb begin
        fast_sel = 1'b1;
        pll_pwd  = 1'b1;
        unique case (state_q)
            ST_MAIN_PLLOFF: begin fast_sel = 1'b1; pll_pwd = 1'b1; end
            ST_MAIN_PLLON:  begin fast_sel = 1'b1; pll_pwd = 1'b0; end
            ST_ON_PLL:      begin fast_sel = 1'b0; pll_pwd = 1'b0; end
            default:        begin fast_sel = 1'b1; pll_pwd = 1'b1; end
        endcase
    end
endmodule

// File: rtl/ccr_plain_bits.sv
module ccr_plain_bits #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q <= '0;
        else if (wr_en) q <= wdata;
    end
endmodule

// File: rtl/ccr_aux_gate.sv
module ccr_aux_gate #(
    parameter int N = 2
) (
    input  logic [N-1:0] en_bits,
    input  logic         main_stable,
    output logic [N-1:0] en_out
);
    for (genvar i = 0; i < N; i++) begin : g_gate
        assign en_out[i] = en_bits[i] & main_stable;
    end
endmodule

// File: rtl/ccr_por_flag.sv
module ccr_por_flag (
    input  logic clk,
    input  logic por,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk or posedge por) begin
        if (por)      flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/clk_src_ctrl.sv
module clk_src_ctrl
    import ccr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 por_i,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_data,
    output logic [REG_W-1:0]     rd_data,
    input  logic                 pll_stable_i,
    input  logic                 main_stable_i,
    output logic                 slow_sel_o,
    output logic                 sys_sel_o,
    output logic                 pll_stop_o,
    output logic [AUX_N-1:0]     aux_en_o
);
    localparam int PLAIN_W = 1 + AUX_N;

    logic               core_rst_n;
    logic               fast_sel, pll_pwd, por_flag;
    logic [PLAIN_W-1:0] plain_d, plain_q;
    logic [AUX_N-1:0]   aux_bits;
    logic               unused_rsvd;

    assign core_rst_n = rst_n & ~por_i;
    assign unused_rsvd = ^wr_data[REG_W-1:POR_BIT+1];

    ccr_src_fsm u_fsm (
        .clk        (clk),
        .rst_n      (core_rst_n),
        .wr_en      (wr_en),
        .req_fast   (wr_data[FAST_BIT]),
        .req_pwd    (wr_data[PWD_BIT]),
        .pll_stable (pll_stable_i),
        .fast_sel   (fast_sel),
        .pll_pwd    (pll_pwd)
    );

    assign plain_d = {wr_data[AUX_LSB +: AUX_N], wr_data[SLOW_BIT]};

    ccr_plain_bits #(.W(PLAIN_W)) u_plain (
        .clk   (clk),
        .rst_n (core_rst_n),
        .wr_en (wr_en),
        .wdata (plain_d),
        .q     (plain_q)
    );

    assign aux_bits = plain_q[PLAIN_W-1:1];

    ccr_aux_gate #(.N(AUX_N)) u_aux (
        .en_bits     (aux_bits),
        .main_stable (main_stable_i),
        .en_out      (aux_en_o)
    );

    ccr_por_flag u_por (
        .clk  (clk),
        .por  (por_i),
        .clr  (wr_en & wr_data[POR_BIT]),
        .flag (por_flag)
    );

    always_comb begin
        rd_data                    = '0;
        rd_data[SLOW_BIT]          = plain_q[0];
        rd_data[FAST_BIT]          = fast_sel;
        rd_data[PWD_BIT]           = pll_pwd;
        rd_data[AUX_LSB +: AUX_N]  = aux_bits;
        rd_data[POR_BIT]           = por_flag;
    end

    assign slow_sel_o = plain_q[0];
    assign sys_sel_o  = fast_sel;
    assign pll_stop_o = pll_pwd;
endmodule

// File: rtl/ccr_checker.sv
module ccr_checker #(
    parameter int RW = 8,
    parameter int AN = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          por_i,
    input logic          wr_en,
    input logic [RW-1:0] wr_data,
    input logic          pll_stable_i,
    input logic          main_stable_i,
    input logic          sys_sel_o,
    input logic          pll_stop_o,
    input logic [AN-1:0] aux_en_o
);
    // R5/R6: PLL never selected while stopped
    assert_no_pll_stop_in_use_R6: assert property (@(posedge clk) disable iff (!rst_n || por_i)
        !(!sys_sel_o && pll_stop_o));

    assert_fast_lock_pwd_R3: assert property (@(posedge clk) disable iff (!rst_n || por_i)
        (wr_en && !wr_data[1] && pll_stop_o) |=> sys_sel_o);

    assert_fast_lock_unstable_R4: assert property (@(posedge clk) disable iff (!rst_n || por_i)
        (wr_en && !wr_data[1] && !pll_stable_i && sys_sel_o) |=> sys_sel_o);

    assert_pwd_lock_R5: assert property (@(posedge clk) disable iff (!rst_n || por_i)
        (wr_en && wr_data[2] && !sys_sel_o) |=> !pll_stop_o);

    assert_fallback_R11: assert property (@(posedge clk) disable iff (!rst_n || por_i)
        (!sys_sel_o && !pll_stable_i) |=> sys_sel_o);

    assert_aux_gated_R8: assert property (@(posedge clk) disable iff (!rst_n || por_i)
        !main_stable_i |-> (aux_en_o == '0));
endmodule

bind clk_src_ctrl ccr_checker #(.RW(ccr_pkg::REG_W), .AN(ccr_pkg::AUX_N)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .por_i         (por_i),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .pll_stable_i  (pll_stable_i),
    .main_stable_i (main_stable_i),
    .sys_sel_o     (sys_sel_o),
    .pll_stop_o    (pll_stop_o),
    .aux_en_o      (aux_en_o)
);

// File: tb/clk_src_ctrl_tb.sv
module clk_src_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por_i = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       pll_stable_i = 1'b1;
    logic       main_stable_i = 1'b1;
    logic       slow_sel_o, sys_sel_o, pll_stop_o;
    logic [1:0] aux_en_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    clk_src_ctrl u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .por_i         (por_i),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .rd_data       (rd_data),
        .pll_stable_i  (pll_stable_i),
        .main_stable_i (main_stable_i),
        .slow_sel_o    (slow_sel_o),
        .sys_sel_o     (sys_sel_o),
        .pll_stop_o    (pll_stop_o),
        .aux_en_o      (aux_en_o)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%02h expected=%02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        por_i = 1'b0; rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset rd_data", rd_data, 8'h26);
        chk("R7 reset pll_stop", {7'd0, pll_stop_o}, 8'h01);
        chk("R7 reset sys_sel", {7'd0, sys_sel_o}, 8'h01);
        chk("R8 reset aux", {6'd0, aux_en_o}, 8'h00);
        chk("R2 reset slow_sel", {7'd0, slow_sel_o}, 8'h00);
    endtask

    task automatic t_por;
        wr(8'h26);
        chk("R9 flag cleared by write", rd_data, 8'h06);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R9 rst_n keeps flag clear", rd_data, 8'h06);
        wr(8'h07);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R9 rst_n resets other bits", rd_data, 8'h06);
        @(negedge clk); por_i = 1'b1;
        @(negedge clk); por_i = 1'b0;
        @(negedge clk);
        chk("R9 por sets flag", rd_data, 8'h26);
        wr(8'h06);
        chk("R9 write 0 keeps flag", rd_data, 8'h26);
        wr(8'h26);
        chk("R9 second clear", rd_data, 8'h06);
    endtask

    task automatic t_slow;
        wr(8'h07);
        chk("R2 slow set", {7'd0, slow_sel_o}, 8'h01);
        chk("R2 slow readback", rd_data, 8'h07);
        wr(8'h06);
        chk("R2 slow cleared", {7'd0, slow_sel_o}, 8'h00);
    endtask

    task automatic t_reserved;
        wr(8'hC6);
        chk("R10 reserved ignored", rd_data, 8'h06);
    endtask

    task automatic t_lock_pwd;
        pll_stable_i = 1'b1;
        wr(8'h00);
        chk("R3 fast kept, pwd cleared", rd_data, 8'h02);
        chk("R7 stop follows pwd", {7'd0, pll_stop_o}, 8'h00);
        chk("R3 sys_sel stays main", {7'd0, sys_sel_o}, 8'h01);
    endtask

    task automatic t_lock_unstable;
        pll_stable_i = 1'b0;
        wr(8'h00);
        chk("R4 fast kept while unstable", rd_data, 8'h02);
        pll_stable_i = 1'b1;
    endtask

    task automatic t_pwd_lock;
        wr(8'h00);
        chk("R7 pll selected", {7'd0, sys_sel_o}, 8'h00);
        wr(8'h04);
        chk("R5 pwd refused on pll", rd_data, 8'h00);
        chk("R5 stop low", {7'd0, pll_stop_o}, 8'h00);
        wr(8'h06);
        chk("R5 combined: fast set, pwd refused", rd_data, 8'h02);
    endtask

    task automatic t_combined;
        wr(8'h04);
        chk("R6 pll wins, pwd refused", rd_data, 8'h00);
        wr(8'h06);
        wr(8'h06);
        chk("R7 power down from main", rd_data, 8'h06);
        chk("R7 stop asserted", {7'd0, pll_stop_o}, 8'h01);
    endtask

    task automatic t_fallback;
        wr(8'h02);
        wr(8'h00);
        chk("R11 on pll before loss", rd_data, 8'h00);
        @(negedge clk); pll_stable_i = 1'b0;
        @(negedge clk);
        chk("R11 forced back to main", rd_data, 8'h02);
        chk("R11 sys_sel main", {7'd0, sys_sel_o}, 8'h01);
        pll_stable_i = 1'b1;
        @(negedge clk);
        chk("R11 stays on main", rd_data, 8'h02);
    endtask

    task automatic t_aux;
        main_stable_i = 1'b1;
        wr(8'h1A);
        chk("R8 both aux on", {6'd0, aux_en_o}, 8'h03);
        main_stable_i = 1'b0;
        #1;
        chk("R8 aux gated by main", {6'd0, aux_en_o}, 8'h00);
        chk("R8 bits held", rd_data, 8'h1A);
        main_stable_i = 1'b1;
        #1;
        chk("R8 aux resume", {6'd0, aux_en_o}, 8'h03);
        wr(8'h0A);
        chk("R8 aux1 only", {6'd0, aux_en_o}, 8'h01);
    endtask

    initial begin
        t_reset();
        t_por();
        t_slow();
        t_reserved();
        t_lock_pwd();
        t_lock_unstable();
        t_pwd_lock();
        t_combined();
        t_fallback();
        t_aux();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog got=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule